// File: doc/BRIEF.md
# POCSAG Batch Synchronizer with Programmable Sync Words

This block sits behind a paging receiver's data slicer. It takes the sliced serial data one bit at a time and finds where each 32-bit codeword starts. It also divides a 76.8 kHz reference tick into the bit-rate enable for 512, 1200 or 2400 bit/s. Every enabled bit is shifted into a 32-bit window, most significant bit first. While the block is hunting, that window is compared on every bit against the standard sync codeword and against four user sync patterns. Each user pattern can be enabled on its own.

An exact match declares lock. From then on the block counts 32-bit codewords through the batch. A batch is one sync slot followed by eight frames of two codewords each. Each completed codeword is emitted with a one-cycle valid pulse, its frame number, its position within the frame and a flag that marks the sync slot. The block also reports which sync pattern was last recognized.

While locked, the block does not look for sync patterns inside message slots. It only checks the slot where the next sync word is due. It gives up lock after two batches in a row whose sync slot holds no recognized pattern.

Top module: `pocsag_batch_sync`

## Requirements
- R1: `bit_en` pulses once for every 150, 64 or 32 `ref_tick` pulses when `rate_sel` is 0, 1 or 2. The value 3 also selects 32.
- R2: Bits enter on `bit_en` with the first received bit as the codeword MSB. While unlocked, a window equal to 0x7CD215D8 sets `locked` in the cycle after that bit. In that same cycle `cw_valid` pulses with `cw_is_sync`=1, `sync_user`=0 and `cw_data` equal to the window.
- R3: User pattern i (bits [32i+31:32i] of `usr_word`) is recognized only when `usr_en[i]` is 1. A hit reports `sync_user`=1 and `sync_id`=i. The standard word takes precedence over an equal user word, and among user words the lowest index wins.
- R4: While locked, `cw_valid` pulses for exactly one cycle after every 32nd bit and at no other time. `cw_data` then holds those 32 bits.
- R5: The n-th codeword after a sync slot (n = 1..16) reports `frame_idx`=(n-1)/2, `cw_in_frame`=(n-1) mod 2 and `cw_is_sync`=0. The 17th codeword reports `cw_is_sync`=1.
- R6: While locked, a sync pattern that arrives in a message slot neither realigns nor changes the slot count.
- R7: A single sync slot without a recognized pattern keeps `locked` high. A recognized pattern at a sync slot clears the miss count.
- R8: A second consecutive sync slot without a recognized pattern drops `locked`, and hunting resumes.
- R9: After reset, `locked` and `cw_valid` are 0.
- R10: While hunting, an alternating preamble and a sync word with one bit wrong do not cause lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One pulse per 76.8 kHz reference period |
| rate_sel | input | 2 | Bit rate: 0=512, 1=1200, 2 or 3=2400 bit/s |
| rx_bit | input | 1 | Sliced serial data, sampled on `bit_en` |
| usr_word | input | 128 | Four user sync patterns, slot i in bits [32i+31:32i] |
| usr_en | input | 4 | Enable per user sync slot |
| bit_en | output | 1 | Bit-rate enable |
| locked | output | 1 | Codeword alignment held |
| cw_valid | output | 1 | One-cycle strobe for a completed codeword |
| cw_data | output | 32 | Completed codeword |
| cw_is_sync | output | 1 | Codeword sits in the sync slot |
| frame_idx | output | 3 | Frame number 0..7 |
| cw_in_frame | output | 1 | Codeword position within its frame |
| sync_user | output | 1 | Last recognized sync was a user pattern |
| sync_id | output | 2 | Index of the last recognized user pattern |

## Verification
Hunting is tried with three kinds of input. An alternating preamble followed by a sync word with one bit flipped separates exact matching from near matching. A user pattern in a disabled slot shows that slot enables are honored. A pattern in an enabled high slot shows that the reported index comes from the matching slot. Once lock is held, two full batches are fed with the sync word placed inside a message slot, which distinguishes a true slot counter from a free-running re-hunt. The sync-slot sequence good, miss, user hit, miss, miss separates a miss counter that clears from one that accumulates, and shows the exact batch in which lock is lost. Each rate code is measured as a count of clock cycles between bit enables.

// File: rtl/pocsag_batch_sync.sv
module pocsag_batch_sync #(
  parameter int CW_W         = 32,
  parameter int N_USR        = 4,
  parameter int DIV_512      = 150,
  parameter int DIV_1200     = 64,
  parameter int DIV_2400     = 32,
  parameter int CW_PER_BATCH = 17,
  parameter int MISS_LIMIT   = 2,
  parameter logic [CW_W-1:0] STD_SYNC = 32'h7CD215D8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ref_tick,
  input  logic [1:0]            rate_sel,
  input  logic                  rx_bit,
  input  logic [N_USR*CW_W-1:0] usr_word,
  input  logic [N_USR-1:0]      usr_en,
  output logic                  bit_en,
  output logic                  locked,
  output logic                  cw_valid,
  output logic [CW_W-1:0]       cw_data,
  output logic                  cw_is_sync,
  output logic [2:0]            frame_idx,
  output logic                  cw_in_frame,
  output logic                  sync_user,
  output logic [$clog2(N_USR)-1:0] sync_id
);
  localparam int DIV_W  = $clog2(DIV_512);
  localparam int BIT_W  = $clog2(CW_W);
  localparam int CNT_W  = $clog2(CW_PER_BATCH);
  localparam int FRM_W  = $clog2(CW_PER_BATCH - 1);
  localparam int ID_W   = $clog2(N_USR);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);

  logic [DIV_W-1:0]  div_m1, div_cnt;
  logic [CW_W-2:0]   sr;
  logic [CW_W-1:0]   win;
  logic [BIT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  cw_cnt;
  logic [FRM_W-1:0]  slot_m1;
  logic [MISS_W-1:0] miss;
  logic              std_hit, usr_any, any_hit;
  logic [ID_W-1:0]   usr_idx;

  always_comb begin
    case (rate_sel)
      2'd0:    div_m1 = DIV_W'(DIV_512 - 1);
      2'd1:    div_m1 = DIV_W'(DIV_1200 - 1);
      default: div_m1 = DIV_W'(DIV_2400 - 1);
    endcase
  end

  assign bit_en = ref_tick && (div_cnt >= div_m1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        div_cnt <= '0;
    else if (ref_tick) div_cnt <= bit_en ? '0 : div_cnt + 1'b1;

  assign win     = {sr, rx_bit};
  assign std_hit = (win == STD_SYNC);
  assign any_hit = std_hit || usr_any;
  assign slot_m1 = FRM_W'(cw_cnt - 1'b1);

  always_comb begin
    usr_any = 1'b0;
    usr_idx = '0;
    for (int i = N_USR - 1; i >= 0; i--)
      if (usr_en[i] && win == usr_word[i*CW_W +: CW_W]) begin
        usr_any = 1'b1;
        usr_idx = ID_W'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; locked <= 1'b0; bit_cnt <= '0; cw_cnt <= '0; miss <= '0;
      cw_valid <= 1'b0; cw_data <= '0; cw_is_sync <= 1'b0;
      frame_idx <= '0; cw_in_frame <= 1'b0; sync_user <= 1'b0; sync_id <= '0;
    end else begin
      cw_valid <= 1'b0;
      if (bit_en) begin
        sr <= win[CW_W-2:0];
        if (!locked) begin
          if (any_hit) begin
            locked <= 1'b1; bit_cnt <= '0; cw_cnt <= CNT_W'(1); miss <= '0;
            cw_valid <= 1'b1; cw_data <= win; cw_is_sync <= 1'b1;
            frame_idx <= '0; cw_in_frame <= 1'b0;
            sync_user <= !std_hit; sync_id <= std_hit ? '0 : usr_idx;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BIT_W'(CW_W - 1)) begin
            cw_valid <= 1'b1;
            cw_data  <= win;
            cw_cnt   <= (cw_cnt == CNT_W'(CW_PER_BATCH - 1)) ? '0 : cw_cnt + 1'b1;
            if (cw_cnt == '0) begin
              cw_is_sync <= 1'b1; frame_idx <= '0; cw_in_frame <= 1'b0;
              if (any_hit) begin
                miss <= '0; sync_user <= !std_hit; sync_id <= std_hit ? '0 : usr_idx;
              end else if (miss == MISS_W'(MISS_LIMIT - 1)) begin
                locked <= 1'b0; miss <= '0;
              end else begin
                miss <= miss + 1'b1;
              end
            end else begin
              cw_is_sync <= 1'b0;
              {frame_idx, cw_in_frame} <= slot_m1;
            end
          end
        end
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) cw_valid |=> !cw_valid); // R4
  AST_VALID_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n) cw_valid |-> $past(bit_en)); // R4
  AST_LOCK_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n) $rose(locked) |-> cw_valid && cw_is_sync); // R2
  AST_DROP_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n) $fell(locked) |-> cw_valid && cw_is_sync); // R8
  AST_ID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !cw_valid |-> $stable({sync_user, sync_id})); // R3
endmodule

// File: tb/pocsag_batch_sync_tb.sv
module pocsag_batch_sync_tb;
  logic         clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b1, rx_bit = 1'b0;
  logic [1:0]   rate_sel = 2'd2;
  logic [127:0] usr_word;
  logic [3:0]   usr_en;
  logic         bit_en, locked, cw_valid, cw_is_sync, cw_in_frame, sync_user;
  logic [31:0]  cw_data;
  logic [2:0]   frame_idx;
  logic [1:0]   sync_id;
  int           n_chk = 0, n_fail = 0;
  logic         early;

  localparam logic [31:0] STD = 32'h7CD215D8;
  localparam logic [9:0] RATE_TAB [4] = '{{2'd0, 8'd150}, {2'd1, 8'd64}, {2'd3, 8'd32}, {2'd2, 8'd32}};
  localparam logic [31:0] MSGS [8] = '{32'h11112222, 32'h80F0E1D2, 32'h0BADCAFE, 32'h55AA33CC,
                                       32'hFFFF0000, 32'h7A5A9696, 32'h01234567, 32'hC3C3A0A0};

  always #2 clk = ~clk;

  pocsag_batch_sync u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rate_sel(rate_sel), .rx_bit(rx_bit),
    .usr_word(usr_word), .usr_en(usr_en), .bit_en(bit_en), .locked(locked),
    .cw_valid(cw_valid), .cw_data(cw_data), .cw_is_sync(cw_is_sync), .frame_idx(frame_idx),
    .cw_in_frame(cw_in_frame), .sync_user(sync_user), .sync_id(sync_id));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_bit = b;
    while (!bit_en) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w);
    early = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      send_bit(w[i]);
      if (i != 0 && cw_valid) early = 1'b1;
    end
  endtask

  task automatic send_msgs(input int tag);
    for (int k = 0; k < 16; k++) begin
      logic [31:0] w;
      w = (tag == 0 && k == 5) ? STD : MSGS[(k + tag) % 8];
      send_word(w);
      chk(cw_valid && !early && cw_data == w, "R4 codeword strobe/data", cw_data, w);
      chk(!cw_is_sync && frame_idx == 3'(k / 2) && cw_in_frame == k[0], "R5/R6 slot position",
          {cw_is_sync, frame_idx, cw_in_frame}, {1'b0, 3'(k / 2), k[0]});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    usr_word = {32'hDEADBEEF, 32'h0F0F1234, 32'hA5A5F00F, STD};
    usr_en   = 4'b1011;
    repeat (3) @(negedge clk);
    chk(!locked && !cw_valid, "R9 reset state", {locked, cw_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 4; r++) begin
      int n;
      rate_sel = RATE_TAB[r][9:8];
      for (int p = 0; p < 2; p++) begin
        while (!bit_en) @(negedge clk);
        @(negedge clk);
        n = 1;
        while (!bit_en) begin @(negedge clk); n++; end
      end
      chk(n == int'(RATE_TAB[r][7:0]), "R1 bit enable period", n, RATE_TAB[r][7:0]);
    end
    rate_sel = 2'd2;

    for (int i = 0; i < 64; i++) send_bit(i[0] ? 1'b0 : 1'b1);
    send_word(STD ^ 32'h00010000);
    chk(!locked, "R10 preamble and near miss ignored", locked, 0);

    send_word(STD);
    chk(locked && cw_valid && cw_is_sync && !sync_user && cw_data == STD, "R2 lock on standard sync",
        {cw_valid, cw_is_sync, sync_user, locked}, 4'b1101);

    send_msgs(0);
    send_word(STD);
    chk(cw_valid && cw_is_sync && locked, "R5 seventeenth slot is sync", {cw_valid, cw_is_sync, locked}, 3'b111);

    send_msgs(1);
    send_word(32'h12345678);
    chk(locked && cw_is_sync, "R7 one miss keeps lock", {locked, cw_is_sync}, 2'b11);

    send_msgs(2);
    send_word(32'hA5A5F00F);
    chk(sync_user && sync_id == 2'd1 && locked, "R3 user slot 1 at sync slot", {sync_user, sync_id}, 3'b101);

    send_msgs(3);
    send_word(32'h00000000);
    chk(locked, "R7 miss count cleared by hit", locked, 1);

    send_msgs(4);
    send_word(32'h00000000);
    chk(!locked && cw_valid, "R8 second consecutive miss drops lock", {locked, cw_valid}, 2'b01);

    send_word(32'h0F0F1234);
    chk(!locked, "R3 disabled user slot ignored", locked, 0);

    send_word(32'hDEADBEEF);
    chk(locked && sync_user && sync_id == 2'd3, "R3 hunting lock on user slot 3",
        {locked, sync_user, sync_id}, 4'b1111);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule